// File: doc/BRIEF.md
# Two-Sided Interrupt Request Handshake

This block connects two processing sides, A and B, so that each can raise general-purpose interrupts and a non-maskable interrupt on the other. A side raises an interrupt by writing a one into a request field of its control register. The matching pending bit then shows in the peer's status register. When the peer clears that pending bit by writing one to it, the request on the originating side retires in the same cycle. While a request is outstanding it cannot be raised again. An attempt to do so is refused and leaves a sticky mark in the requester's status register.

Each side also has per-interrupt enables and a single level interrupt output. A side can send a unit-reset notification to its peer. When the peer enables it, that notification is merged into the line of general interrupt 3. The non-maskable request drives a dedicated output on the peer and has its own clear bit. Both sides are identical and talk to the block through a one-cycle register write port and a combinational read port.

Top module: `peer_irq_bridge`

## Requirements
- R1: After reset, both control and status registers of both sides read zero, and all irq and nmi outputs are low.
- R2: Request field is control bits [7:4] in reversed order (bit 7 = interrupt 0, bit 4 = interrupt 3). Writing 1 to the bit of interrupt n sets pending n on the peer at status bit 3-n, visible after the write's clock edge.
- R3: A request reads back as 1 in the requester's control bits [7:4] while outstanding. It reads 0 from the edge at which the peer clears the matching pending bit.
- R4: Writing 0 to request bits (control [8:4]) never withdraws an outstanding request.
- R5: Writing 1 to a request bit (general or NMI) that is already outstanding leaves the pending state unchanged. It also sets the requester's sticky reject flag, status bit 7, which stays set until reset.
- R6: Status bits [3:0] and bit 6 are write-one-to-clear. Writes to status bit 4 (NMI pending) and bit 7 (reject) have no effect.
- R7: Control bit 8 requests an NMI on the peer. The peer's nmi output and status bit 4 stay high until the peer writes 1 to status bit 5. Status bit 5 reads 0.
- R8: Control bits [3:0] are the enables in reversed order (bit 3 = interrupt 0). The irq output is high exactly when some pending general interrupt has its enable set, or when the merged reset notification of R9 is active.
- R9: Writing 1 to control bit 10 sets status bit 6 on the peer. Control bit 10 always reads 0. Control bit 9 enables status bit 6 onto the interrupt 3 line of irq.
- R10: When a side re-triggers interrupt n in the same cycle that the peer clears pending n, the clear takes effect and the trigger is refused as in R5. If pending n was clear, the trigger sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr_en | input | 1 | Side A register write strobe |
| a_wr_sel | input | 1 | Side A write target: 0 control, 1 status |
| a_wr_data | input | 11 | Side A write data |
| a_rd_sel | input | 1 | Side A read target: 0 control, 1 status |
| a_rd_data | output | 11 | Side A read data |
| a_irq | output | 1 | Side A maskable interrupt |
| a_nmi | output | 1 | Side A non-maskable interrupt |
| b_wr_en | input | 1 | Side B register write strobe |
| b_wr_sel | input | 1 | Side B write target: 0 control, 1 status |
| b_wr_data | input | 11 | Side B write data |
| b_rd_sel | input | 1 | Side B read target: 0 control, 1 status |
| b_rd_data | output | 11 | Side B read data |
| b_irq | output | 1 | Side B maskable interrupt |
| b_nmi | output | 1 | Side B non-maskable interrupt |

## Verification
A re-trigger from one side and the acknowledge from the other side can land on the same clock edge for the same interrupt. The bench provokes this by driving both write ports within one cycle. It first does so with the interrupt outstanding, and expects the pending bit to be cleared and the requester's reject flag to be set. It then does so with the interrupt idle, and expects the pending bit to be set and no clear to be lost. Register reads and the irq and nmi outputs of both sides judge each outcome.

// File: rtl/peer_irq_pkg.sv
package peer_irq_pkg;
  localparam int unsigned GP_N   = 4;
  // control register layout
  localparam int unsigned C_EN_LSB  = 0;
  localparam int unsigned C_REQ_LSB = GP_N;
  localparam int unsigned C_NMI_REQ = 2 * GP_N;
  localparam int unsigned C_RN_EN   = 2 * GP_N + 1;
  localparam int unsigned C_RN_TRIG = 2 * GP_N + 2;
  // status register layout
  localparam int unsigned S_PEND_LSB = 0;
  localparam int unsigned S_NMI_PEND = GP_N;
  localparam int unsigned S_NMI_CLR  = GP_N + 1;
  localparam int unsigned S_RN_PEND  = GP_N + 2;
  localparam int unsigned S_REJECT   = GP_N + 3;
  localparam int unsigned DATA_W     = C_RN_TRIG + 1;
  localparam logic        SEL_STAT   = 1'b1;

  typedef logic [GP_N-1:0] gp_vec_t;

  // one direction's events: general interrupts, NMI, reset notification
  typedef struct packed {
    gp_vec_t gp;
    logic    nmi;
    logic    rn;
  } evt_t;

  // register fields carry interrupt 0 in the top bit
  function automatic gp_vec_t flip_gp(input gp_vec_t v);
    gp_vec_t r;
    for (int i = 0; i < GP_N; i++) r[i] = v[GP_N-1-i];
    return r;
  endfunction
endpackage

// File: rtl/peer_irq_rst_sync.sv
module peer_irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;
endmodule

// File: rtl/peer_irq_channel.sv
// Pending state for one direction: set by the requester, cleared by the peer.
module peer_irq_channel
  import peer_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  evt_t trig,
  input  evt_t ack,
  output evt_t pend,
  output logic refused
);
  evt_t pend_q, pend_nx;
  logic upd;

  always_comb begin
    pend_nx     = pend_q;
    // trigger only acts on an idle bit, clear only on a set bit
    pend_nx.gp  = (pend_q.gp & ~ack.gp) | (trig.gp & ~pend_q.gp);
    pend_nx.nmi = (pend_q.nmi & ~ack.nmi) | (trig.nmi & ~pend_q.nmi);
    // notification has no handshake: a new event wins over a clear
    pend_nx.rn  = (pend_q.rn & ~ack.rn) | trig.rn;
    upd         = (|trig) | (|ack);
    refused     = (|(trig.gp & pend_q.gp)) | (trig.nmi & pend_q.nmi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else if (upd) pend_q <= pend_nx;
  end

  assign pend = pend_q;
endmodule

// File: rtl/peer_irq_side.sv
// Register port, enables and interrupt outputs of one side.
module peer_irq_side
  import peer_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  input  evt_t              inbound,
  input  gp_vec_t           out_gp,
  input  logic              out_nmi,
  input  logic              refused,
  output evt_t              trig,
  output evt_t              ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              nmi,
  output logic              rej
);
  gp_vec_t en_q, en_nx;
  logic    rn_en_q, rn_en_nx;
  logic    rej_q;
  logic    wr_ctrl, wr_stat, cfg_ce, rej_ce;
  gp_vec_t line;
  logic [DATA_W-1:0] ctrl_img, stat_img;

  always_comb begin
    wr_ctrl  = wr_en && (wr_sel != SEL_STAT);
    wr_stat  = wr_en && (wr_sel == SEL_STAT);

    trig     = '0;
    trig.gp  = wr_ctrl ? flip_gp(wr_data[C_REQ_LSB +: GP_N]) : '0;
    trig.nmi = wr_ctrl & wr_data[C_NMI_REQ];
    trig.rn  = wr_ctrl & wr_data[C_RN_TRIG];

    ack      = '0;
    ack.gp   = wr_stat ? flip_gp(wr_data[S_PEND_LSB +: GP_N]) : '0;
    ack.nmi  = wr_stat & wr_data[S_NMI_CLR];
    ack.rn   = wr_stat & wr_data[S_RN_PEND];

    cfg_ce   = wr_ctrl;
    en_nx    = flip_gp(wr_data[C_EN_LSB +: GP_N]);
    rn_en_nx = wr_data[C_RN_EN];
    rej_ce   = refused & ~rej_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      rn_en_q <= 1'b0;
    end else if (cfg_ce) begin
      en_q    <= en_nx;
      rn_en_q <= rn_en_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rej_q <= 1'b0;
    else if (rej_ce) rej_q <= 1'b1;
  end

  always_comb begin
    line           = inbound.gp & en_q;
    line[GP_N-1]   = line[GP_N-1] | (inbound.rn & rn_en_q);

    ctrl_img                         = '0;
    ctrl_img[C_EN_LSB +: GP_N]       = flip_gp(en_q);
    ctrl_img[C_REQ_LSB +: GP_N]      = flip_gp(out_gp);
    ctrl_img[C_NMI_REQ]              = out_nmi;
    ctrl_img[C_RN_EN]                = rn_en_q;

    stat_img                         = '0;
    stat_img[S_PEND_LSB +: GP_N]     = flip_gp(inbound.gp);
    stat_img[S_NMI_PEND]             = inbound.nmi;
    stat_img[S_RN_PEND]              = inbound.rn;
    stat_img[S_REJECT]               = rej_q;
  end

  assign rd_data = (rd_sel == SEL_STAT) ? stat_img : ctrl_img;
  assign irq     = |line;
  assign nmi     = inbound.nmi;
  assign rej     = rej_q;
endmodule

// File: rtl/peer_irq_bridge.sv
module peer_irq_bridge
  import peer_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_wr_en,
  input  logic              a_wr_sel,
  input  logic [DATA_W-1:0] a_wr_data,
  input  logic              a_rd_sel,
  output logic [DATA_W-1:0] a_rd_data,
  output logic              a_irq,
  output logic              a_nmi,
  input  logic              b_wr_en,
  input  logic              b_wr_sel,
  input  logic [DATA_W-1:0] b_wr_data,
  input  logic              b_rd_sel,
  output logic [DATA_W-1:0] b_rd_data,
  output logic              b_irq,
  output logic              b_nmi
);
  localparam int unsigned SIDES = 2;

  logic              rst_n_s;
  logic              wr_en_v   [SIDES];
  logic              wr_sel_v  [SIDES];
  logic [DATA_W-1:0] wr_data_v [SIDES];
  logic              rd_sel_v  [SIDES];
  logic [DATA_W-1:0] rd_data_v [SIDES];
  logic              irq_v     [SIDES];
  logic              nmi_v     [SIDES];
  logic              rej_v     [SIDES];
  logic              refused_v [SIDES];
  evt_t              trig_v    [SIDES];
  evt_t              ack_v     [SIDES];
  // pend_v[s]: raised by side s, pending at the other side
  evt_t              pend_v    [SIDES];

  peer_irq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  assign wr_en_v[0]   = a_wr_en;
  assign wr_sel_v[0]  = a_wr_sel;
  assign wr_data_v[0] = a_wr_data;
  assign rd_sel_v[0]  = a_rd_sel;
  assign wr_en_v[1]   = b_wr_en;
  assign wr_sel_v[1]  = b_wr_sel;
  assign wr_data_v[1] = b_wr_data;
  assign rd_sel_v[1]  = b_rd_sel;

  assign a_rd_data = rd_data_v[0];
  assign a_irq     = irq_v[0];
  assign a_nmi     = nmi_v[0];
  assign b_rd_data = rd_data_v[1];
  assign b_irq     = irq_v[1];
  assign b_nmi     = nmi_v[1];

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    localparam int unsigned PEER = SIDES - 1 - s;

    peer_irq_channel u_chan (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .trig    (trig_v[s]),
      .ack     (ack_v[PEER]),
      .pend    (pend_v[s]),
      .refused (refused_v[s])
    );

    peer_irq_side u_side (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .wr_en   (wr_en_v[s]),
      .wr_sel  (wr_sel_v[s]),
      .wr_data (wr_data_v[s]),
      .rd_sel  (rd_sel_v[s]),
      .inbound (pend_v[PEER]),
      .out_gp  (pend_v[s].gp),
      .out_nmi (pend_v[s].nmi),
      .refused (refused_v[s]),
      .trig    (trig_v[s]),
      .ack     (ack_v[s]),
      .rd_data (rd_data_v[s]),
      .irq     (irq_v[s]),
      .nmi     (nmi_v[s]),
      .rej     (rej_v[s])
    );
  end
endmodule

// File: rtl/peer_irq_chk.sv
module peer_irq_chk
  import peer_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              a_wr_en,
  input logic              a_wr_sel,
  input logic [DATA_W-1:0] a_wr_data,
  input logic              b_wr_en,
  input logic              b_wr_sel,
  input logic [DATA_W-1:0] b_wr_data,
  input logic              a_irq,
  input logic              a_nmi,
  input logic              b_irq,
  input logic              b_nmi,
  input evt_t              ab_pend,
  input evt_t              ba_pend,
  input logic              a_rej,
  input logic              b_rej
);
  logic    a_ctrl, a_stat, b_ctrl, b_stat;
  gp_vec_t a_req, b_req, a_clr, b_clr;

  always_comb begin
    a_ctrl = a_wr_en && (a_wr_sel != SEL_STAT);
    a_stat = a_wr_en && (a_wr_sel == SEL_STAT);
    b_ctrl = b_wr_en && (b_wr_sel != SEL_STAT);
    b_stat = b_wr_en && (b_wr_sel == SEL_STAT);
    a_req  = a_ctrl ? flip_gp(a_wr_data[C_REQ_LSB +: GP_N]) : '0;
    b_req  = b_ctrl ? flip_gp(b_wr_data[C_REQ_LSB +: GP_N]) : '0;
    a_clr  = a_stat ? flip_gp(a_wr_data[S_PEND_LSB +: GP_N]) : '0;
    b_clr  = b_stat ? flip_gp(b_wr_data[S_PEND_LSB +: GP_N]) : '0;
  end

  assert_req_held_ab_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ab_pend.gp) & ~$past(b_clr) & ~ab_pend.gp) == '0));
  assert_req_held_ba_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ba_pend.gp) & ~$past(a_clr) & ~ba_pend.gp) == '0));

  assert_refuse_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ctrl && (((a_req & ab_pend.gp) != '0) || (a_wr_data[C_NMI_REQ] && ab_pend.nmi))) |=> a_rej);
  assert_refuse_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (b_ctrl && (((b_req & ba_pend.gp) != '0) || (b_wr_data[C_NMI_REQ] && ba_pend.nmi))) |=> b_rej);
  assert_reject_sticky_a_R5: assert property (@(posedge clk) disable iff (!rst_n) a_rej |=> a_rej);
  assert_reject_sticky_b_R5: assert property (@(posedge clk) disable iff (!rst_n) b_rej |=> b_rej);

  assert_nmi_held_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (b_nmi && !(b_stat && b_wr_data[S_NMI_CLR])) |=> b_nmi);
  assert_nmi_held_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (a_nmi && !(a_stat && a_wr_data[S_NMI_CLR])) |=> a_nmi);
  assert_nmi_origin_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_nmi) |-> $past(a_ctrl && a_wr_data[C_NMI_REQ]));
  assert_nmi_origin_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_nmi) |-> $past(b_ctrl && b_wr_data[C_NMI_REQ]));

  assert_irq_cause_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    a_irq |-> ((ba_pend.gp != '0) || ba_pend.rn));
  assert_irq_cause_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    b_irq |-> ((ab_pend.gp != '0) || ab_pend.rn));

  assert_notify_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ctrl && a_wr_data[C_RN_TRIG]) |=> ab_pend.rn);
  assert_notify_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (b_ctrl && b_wr_data[C_RN_EN] && ab_pend.rn) |=> b_irq);
  assert_notify_set_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (b_ctrl && b_wr_data[C_RN_TRIG]) |=> ba_pend.rn);
  assert_notify_irq_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ctrl && a_wr_data[C_RN_EN] && ba_pend.rn) |=> a_irq);
endmodule

bind peer_irq_bridge peer_irq_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .a_wr_en   (a_wr_en),
  .a_wr_sel  (a_wr_sel),
  .a_wr_data (a_wr_data),
  .b_wr_en   (b_wr_en),
  .b_wr_sel  (b_wr_sel),
  .b_wr_data (b_wr_data),
  .a_irq     (a_irq),
  .a_nmi     (a_nmi),
  .b_irq     (b_irq),
  .b_nmi     (b_nmi),
  .ab_pend   (pend_v[0]),
  .ba_pend   (pend_v[1]),
  .a_rej     (rej_v[0]),
  .b_rej     (rej_v[1])
);

// File: tb/peer_irq_bridge_tb.sv
`timescale 1ns/1ps
module peer_irq_bridge_tb_top;
  logic        clk;
  logic        rst_n;
  logic        a_wr_en, a_wr_sel, a_rd_sel, a_irq, a_nmi;
  logic        b_wr_en, b_wr_sel, b_rd_sel, b_irq, b_nmi;
  logic [10:0] a_wr_data, b_wr_data, a_rd_data, b_rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    int          side;
    logic        sel;
    logic [10:0] data;
    logic        irq;
    logic        nmi;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  // model from the requirements; index s = requester, its pending sits at 1-s
  logic [3:0] m_gp   [2];
  logic       m_nmi  [2];
  logic       m_rn   [2];
  logic [3:0] m_en   [2];
  logic       m_rnen [2];
  logic       m_rej  [2];

  peer_irq_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_wr_en(a_wr_en), .a_wr_sel(a_wr_sel), .a_wr_data(a_wr_data),
    .a_rd_sel(a_rd_sel), .a_rd_data(a_rd_data), .a_irq(a_irq), .a_nmi(a_nmi),
    .b_wr_en(b_wr_en), .b_wr_sel(b_wr_sel), .b_wr_data(b_wr_data),
    .b_rd_sel(b_rd_sel), .b_rd_data(b_rd_data), .b_irq(b_irq), .b_nmi(b_nmi)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [3:0] rv(input logic [3:0] v);
    return {v[0], v[1], v[2], v[3]};
  endfunction

  // control word: enables/requests given interrupt-indexed (bit n = interrupt n)
  function automatic logic [10:0] cw(input logic [3:0] en, input logic [3:0] req,
                                     input logic nmi, input logic rnen, input logic rntrig);
    return {rntrig, rnen, nmi, rv(req), rv(en)};
  endfunction

  function automatic logic [10:0] sw(input logic [3:0] clr, input logic nmi_pend_bit,
                                     input logic nmiclr, input logic rnclr, input logic rej_bit);
    return {3'b000, rej_bit, rnclr, nmiclr, nmi_pend_bit, rv(clr)};
  endfunction

  function automatic sb_item_t expect_of(input int s, input logic sel, input string tag);
    sb_item_t it;
    int p = 1 - s;
    it.side = s;
    it.sel  = sel;
    it.tag  = tag;
    if (sel) it.data = {3'b000, m_rej[s], m_rn[p], 1'b0, m_nmi[p], rv(m_gp[p])};
    else     it.data = {1'b0, m_rnen[s], m_nmi[s], rv(m_gp[s]), rv(m_en[s])};
    it.irq = (|(m_gp[p] & m_en[s])) | (m_rn[p] & m_rnen[s]);
    it.nmi = m_nmi[p];
    return it;
  endfunction

  task automatic chk(input int s, input logic sel, input string tag);
    sb_q.push_back(expect_of(s, sel, tag));
    while (sb_q.size() != 0) @(posedge clk);
  endtask

  task automatic do_wr(input logic ae, input logic as_, input logic [10:0] ad,
                       input logic be, input logic bs, input logic [10:0] bd);
    logic        e [2];
    logic        sl[2];
    logic [10:0] d [2];
    logic [3:0]  ngp[2];
    logic        nnmi[2];
    logic        nrn[2];
    e[0] = ae; sl[0] = as_; d[0] = ad;
    e[1] = be; sl[1] = bs;  d[1] = bd;
    @(negedge clk);
    a_wr_en = ae; a_wr_sel = as_; a_wr_data = ad;
    b_wr_en = be; b_wr_sel = bs;  b_wr_data = bd;
    for (int s = 0; s < 2; s++) begin
      int p = 1 - s;
      logic ctl, stp;
      logic [3:0] trg, clr;
      logic tn, tr, cn, cr;
      ctl = e[s] && !sl[s];
      stp = e[p] && sl[p];
      trg = ctl ? rv(d[s][7:4]) : 4'b0;
      tn  = ctl && d[s][8];
      tr  = ctl && d[s][10];
      clr = stp ? rv(d[p][3:0]) : 4'b0;
      cn  = stp && d[p][5];
      cr  = stp && d[p][6];
      if (((trg & m_gp[s]) != 4'b0) || (tn && m_nmi[s])) m_rej[s] = 1'b1;
      ngp[s]  = (m_gp[s] & ~clr) | (trg & ~m_gp[s]);
      nnmi[s] = (m_nmi[s] & ~cn) | (tn & ~m_nmi[s]);
      nrn[s]  = (m_rn[s] & ~cr) | tr;
      if (ctl) begin
        m_en[s]   = rv(d[s][3:0]);
        m_rnen[s] = d[s][9];
      end
    end
    for (int s = 0; s < 2; s++) begin
      m_gp[s] = ngp[s]; m_nmi[s] = nnmi[s]; m_rn[s] = nrn[s];
    end
    @(negedge clk);
    a_wr_en = 1'b0; b_wr_en = 1'b0;
  endtask

  task automatic wa(input logic sel, input logic [10:0] d);
    do_wr(1'b1, sel, d, 1'b0, 1'b0, 11'h0);
  endtask
  task automatic wb(input logic sel, input logic [10:0] d);
    do_wr(1'b0, 1'b0, 11'h0, 1'b1, sel, d);
  endtask

  // monitor: pops expected items and compares with the ports
  initial begin
    a_rd_sel = 1'b0;
    b_rd_sel = 1'b0;
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        sb_item_t it;
        logic [10:0] gd;
        logic gi, gn;
        it = sb_q[0];
        if (it.side == 0) a_rd_sel = it.sel; else b_rd_sel = it.sel;
        #1;
        gd = (it.side == 0) ? a_rd_data : b_rd_data;
        gi = (it.side == 0) ? a_irq : b_irq;
        gn = (it.side == 0) ? a_nmi : b_nmi;
        n_cmp++;
        if (gd !== it.data || gi !== it.irq || gn !== it.nmi) begin
          n_bad++;
          $display("FAIL %s side=%0d sel=%0d: actual data=%h irq=%b nmi=%b expected data=%h irq=%b nmi=%b",
                   it.tag, it.side, it.sel, gd, gi, gn, it.data, it.irq, it.nmi);
        end
        void'(sb_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      m_gp[s] = 4'b0; m_nmi[s] = 1'b0; m_rn[s] = 1'b0;
      m_en[s] = 4'b0; m_rnen[s] = 1'b0; m_rej[s] = 1'b0;
    end
    rst_n = 1'b0;
    a_wr_en = 1'b0; a_wr_sel = 1'b0; a_wr_data = '0;
    b_wr_en = 1'b0; b_wr_sel = 1'b0; b_wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(0, 1'b0, "R1"); chk(0, 1'b1, "R1"); chk(1, 1'b0, "R1"); chk(1, 1'b1, "R1");

    // R2/R3: B enables 0 and 2, A raises interrupt 0
    wb(1'b0, cw(4'b0101, 4'b0, 1'b0, 1'b0, 1'b0));
    wa(1'b0, cw(4'b0000, 4'b0001, 1'b0, 1'b0, 1'b0));
    chk(1, 1'b1, "R2"); chk(0, 1'b0, "R3");

    // R5: re-trigger of outstanding interrupt 0
    wa(1'b0, cw(4'b0000, 4'b0001, 1'b0, 1'b0, 1'b0));
    chk(0, 1'b1, "R5"); chk(1, 1'b1, "R5");

    // R8: interrupt 1 pending but not enabled on B
    wa(1'b0, cw(4'b0000, 4'b0010, 1'b0, 1'b0, 1'b0));
    chk(1, 1'b0, "R8"); chk(1, 1'b1, "R8");

    // R6/R3: B clears interrupt 0 only
    wb(1'b1, sw(4'b0001, 1'b0, 1'b0, 1'b0, 1'b0));
    chk(1, 1'b1, "R6"); chk(0, 1'b0, "R3");

    // R4: writing zeros to request bits
    wa(1'b0, cw(4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0));
    chk(0, 1'b0, "R4"); chk(1, 1'b1, "R4");

    // R7: NMI raise, ignored writes, refused re-raise, clear
    wa(1'b0, cw(4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0));
    chk(1, 1'b1, "R7"); chk(0, 1'b0, "R7");
    wb(1'b1, sw(4'b0000, 1'b1, 1'b0, 1'b0, 1'b1));
    chk(1, 1'b1, "R6");
    wa(1'b0, cw(4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0));
    chk(1, 1'b1, "R7");
    wb(1'b1, sw(4'b0000, 1'b0, 1'b1, 1'b0, 1'b0));
    chk(1, 1'b1, "R7"); chk(0, 1'b0, "R7");

    // R9: reset notification, then enable onto interrupt 3 line, then clear
    wa(1'b0, cw(4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1));
    chk(1, 1'b1, "R9"); chk(0, 1'b0, "R9");
    wb(1'b0, cw(4'b0101, 4'b0000, 1'b0, 1'b1, 1'b0));
    chk(1, 1'b1, "R9"); chk(1, 1'b0, "R9");
    wb(1'b1, sw(4'b0000, 1'b0, 1'b0, 1'b1, 1'b0));
    chk(1, 1'b1, "R9");

    // R10: B raises 3 to A, A enables 3
    wa(1'b0, cw(4'b1000, 4'b0000, 1'b0, 1'b0, 1'b0));
    wb(1'b0, cw(4'b0101, 4'b1000, 1'b0, 1'b1, 1'b0));
    chk(0, 1'b1, "R10"); chk(1, 1'b0, "R10");
    // same cycle: B re-raises 3 while A clears 3
    do_wr(1'b1, 1'b1, sw(4'b1000, 1'b0, 1'b0, 1'b0, 1'b0),
          1'b1, 1'b0, cw(4'b0101, 4'b1000, 1'b0, 1'b1, 1'b0));
    chk(0, 1'b1, "R10"); chk(1, 1'b1, "R10");
    // same cycle: A clears idle 2 while B raises 2
    do_wr(1'b1, 1'b1, sw(4'b0100, 1'b0, 1'b0, 1'b0, 1'b0),
          1'b1, 1'b0, cw(4'b0101, 4'b0100, 1'b0, 1'b1, 1'b0));
    chk(0, 1'b1, "R10"); chk(1, 1'b0, "R10");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule